// File: doc/BRIEF.md
# NAND Flash Bus Cycle Generator

This block turns single bus-cycle requests into the strobe sequences of an asynchronous NAND flash device on a 16-bit address/data bus. A requester hands over one cycle at a time: a command latch, an address latch, a data write or a data read. The block drives chip select, the command and address latch enables, the write strobe and the read strobe. It controls the direction of the data bus. Before a read it waits for the device's ready/busy line.

Every timing minimum is a nanosecond parameter. At elaboration it is rounded up to whole clock cycles, with a floor of one cycle. Each hold time applies to its own signal. After the write strobe rises, the latch enables stay up for their longer hold. The data bus is released after its shorter hold. Chip select is released after its own hold, which differs for write-type and read cycles. The request carries an end-of-burst flag. When the flag is clear, chip select stays low after the cycle so that sequential cycles share one selection.

Both data-carrying edges use valid/ready. On the request side, the requester holds `req_valid` and the request fields steady until `req_ready` is seen high at a clock edge. Only one cycle is in flight at a time, so `req_ready` stays low from acceptance until completion. On the read-data side, the block holds `rd_valid` and `rd_data` until `rd_ready` is high at a clock edge. While the consumer back-pressures, the block stays busy and accepts no new request. `done` is a plain one-cycle pulse.

Top module: `nand_cycle_gen`

With the default parameters at a 4 ns clock, the timings are:

| Name | Meaning | Cycles |
|------|---------|--------|
| WL | write strobe low time | 5 |
| LH | latch hold after the write strobe rises | 10 |
| DH | data hold after the write strobe rises | 5 |
| CEW | chip-select hold after a write-type cycle | 3 |
| WHT | write tail | 10 |
| RR | ready-to-read-strobe gap | 5 |
| RL | read strobe low time | 5 |
| CER | chip-select hold after a read | 8 |
| RHT | read tail | 8 |

## Requirements
- R1: After reset, the outputs are as follows. Chip select, the write strobe and the read strobe are high. Both latch enables and `nf_doe` are low. `req_ready` is high. `done` and `rd_valid` are low.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. The `req_kind` encoding is 0 for command, 1 for address, 2 for data write and 3 for read. `req_ready` stays low from acceptance until the `done` pulse.
- R3: A write-type cycle pulls `nf_wr_n` low for exactly WL cycles. WL is the largest of the rounded latch setup, data setup and write pulse minimums. For the whole pulse, `nf_cmd_lat` is high only for kind 0, `nf_adr_lat` is high only for kind 1, and the bus is driven with the request word.
- R4: After the write strobe rises, the active latch enable stays high for exactly LH cycles, the rounded latch hold.
- R5: After the write strobe rises, `nf_doe` stays high with the word unchanged for exactly DH cycles, the rounded data hold.
- R6: `done` pulses for one cycle after WHT cycles of write strobe high time. WHT is the largest of LH, DH, CEW, the rounded write-high minimum, and the rounded write-cycle minimum less WL.
- R7: The read strobe falls only after the synchronized ready line has been high for RR consecutive edges. Any low sample restarts the count. Measured at the pins, the gap is RR+SYNC_STAGES-1 cycles of the `nf_rdy` input being high.
- R8: The read strobe stays low for exactly RL cycles. `rd_data` is the value on `nf_din` at the clock edge where the strobe rises. `nf_doe` is low throughout a read cycle.
- R9: `rd_valid` rises after RHT cycles of read strobe high time. RHT is the largest of the rounded read-high minimum, the rounded read-cycle minimum less RL, and CER. `rd_data` is stable while `rd_valid` is high and `rd_ready` is low. `done` pulses one cycle after the read-data handshake.
- R10: Chip select falls at acceptance. With `req_last` set, it rises CEW cycles after the write strobe rises, or CER cycles after the read strobe rises. With `req_last` clear, it stays low until the next cycle.
- R11: The write and read strobes are never low together, and the two latch enables are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_kind | input | 2 | Cycle kind: 0 command, 1 address, 2 write, 3 read |
| req_last | input | 1 | Release chip select after this cycle |
| req_wdata | input | DW | Word for write-type cycles |
| rd_valid | output | 1 | Read word valid |
| rd_ready | input | 1 | Consumer ready for read word |
| rd_data | output | DW | Captured read word |
| done | output | 1 | One-cycle completion pulse |
| nf_cs_n | output | 1 | Flash chip select, active low |
| nf_cmd_lat | output | 1 | Command latch enable |
| nf_adr_lat | output | 1 | Address latch enable |
| nf_wr_n | output | 1 | Write strobe, active low |
| nf_rd_n | output | 1 | Read strobe, active low |
| nf_rdy | input | 1 | Device ready (high) / busy (low) |
| nf_dout | output | DW | Bus value driven on writes |
| nf_doe | output | 1 | Bus output enable |
| nf_din | input | DW | Bus value sampled on reads |

## Verification
The assertions rely on a few properties of the inputs:

- The ready gap check counts raw `nf_rdy` high cycles. It therefore assumes that the line, once high, stays high until the read strobe falls, and that it is lowered some cycles before each read so that no stale synchronizer state is carried over.
- The stall check assumes the consumer raises `rd_ready` only by its own choice. The requester changes its fields only between requests.

The stimulus changes every input at falling clock edges. It drops `nf_rdy` for a short glitch only while the strobe is still waiting. It holds `nf_rdy` low for three idle cycles before each read is issued.

// File: rtl/nfb_pkg.sv
package nfb_pkg;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WRITE = 2'd2,
    K_READ  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WLOW,
    S_WHOLD,
    S_RWAIT,
    S_RLOW,
    S_RHOLD,
    S_RSP
  } state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nfb_rdy_sync.sv
module nfb_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nfb_rd_hold.sv
module nfb_rd_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic          present,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      if (cap) data <= din;
      if (present)   valid <= 1'b1;
      else if (take) valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nfb_seq.sv
module nfb_seq
  import nfb_pkg::*;
#(
  parameter int DW  = 16,
  parameter int WL  = 5,
  parameter int LH  = 10,
  parameter int DH  = 5,
  parameter int CEW = 3,
  parameter int WHT = 10,
  parameter int RR  = 5,
  parameter int RL  = 5,
  parameter int CER = 8,
  parameter int RHT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_last,
  input  logic [DW-1:0] req_wdata,
  input  logic          rdy_s,
  input  logic          rd_take,
  output logic          req_ready,
  output logic          cs_n,
  output logic          cmd_lat,
  output logic          adr_lat,
  output logic          wr_n,
  output logic          rd_n,
  output logic          doe,
  output logic [DW-1:0] dout,
  output logic          cap_en,
  output logic          present,
  output logic          done
);
  localparam int MAXC = imax(imax(imax(WL, LH), imax(DH, CEW)),
                             imax(imax(WHT, RR), imax(imax(RL, CER), RHT)));
  localparam int CW = $clog2(MAXC + 1);

  localparam logic [CW-1:0] WL_E  = CW'(WL - 1);
  localparam logic [CW-1:0] LH_E  = CW'(LH - 1);
  localparam logic [CW-1:0] DH_E  = CW'(DH - 1);
  localparam logic [CW-1:0] CEW_E = CW'(CEW - 1);
  localparam logic [CW-1:0] WHT_E = CW'(WHT - 1);
  localparam logic [CW-1:0] RR_E  = CW'(RR - 1);
  localparam logic [CW-1:0] RL_E  = CW'(RL - 1);
  localparam logic [CW-1:0] CER_E = CW'(CER - 1);
  localparam logic [CW-1:0] RHT_E = CW'(RHT - 1);

  state_e        state;
  logic [CW-1:0] cnt;
  logic          last_q;

  assign req_ready = (state == S_IDLE);
  assign cap_en    = (state == S_RLOW)  && (cnt == RL_E);
  assign present   = (state == S_RHOLD) && (cnt == RHT_E);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      last_q  <= 1'b0;
      cs_n    <= 1'b1;
      cmd_lat <= 1'b0;
      adr_lat <= 1'b0;
      wr_n    <= 1'b1;
      rd_n    <= 1'b1;
      doe     <= 1'b0;
      dout    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            last_q <= req_last;
            cnt    <= '0;
            cs_n   <= 1'b0;
            if (req_kind == K_READ) begin
              state <= S_RWAIT;
            end else begin
              state   <= S_WLOW;
              wr_n    <= 1'b0;
              cmd_lat <= (req_kind == K_CMD);
              adr_lat <= (req_kind == K_ADDR);
              doe     <= 1'b1;
              dout    <= req_wdata;
            end
          end
        end
        S_WLOW: begin
          if (cnt == WL_E) begin
            wr_n  <= 1'b1;
            cnt   <= '0;
            state <= S_WHOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WHOLD: begin
          if (cnt == LH_E) begin
            cmd_lat <= 1'b0;
            adr_lat <= 1'b0;
          end
          if (cnt == DH_E) doe <= 1'b0;
          if (last_q && (cnt == CEW_E)) cs_n <= 1'b1;
          if (cnt == WHT_E) begin
            state <= S_IDLE;
            cnt   <= '0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RWAIT: begin
          if (!rdy_s) begin
            cnt <= '0;
          end else if (cnt == RR_E) begin
            rd_n  <= 1'b0;
            cnt   <= '0;
            state <= S_RLOW;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RLOW: begin
          if (cnt == RL_E) begin
            rd_n  <= 1'b1;
            cnt   <= '0;
            state <= S_RHOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RHOLD: begin
          if (last_q && (cnt == CER_E)) cs_n <= 1'b1;
          if (cnt == RHT_E) begin
            cnt   <= '0;
            state <= S_RSP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RSP: begin
          if (rd_take) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_cycle_gen.sv
module nand_cycle_gen
  import nfb_pkg::*;
#(
  parameter int DW            = 16,
  parameter int CLK_NS        = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int T_LSU_NS      = 20,
  parameter int T_LHD_NS      = 40,
  parameter int T_WP_NS       = 20,
  parameter int T_WH_NS       = 20,
  parameter int T_WC_NS       = 40,
  parameter int T_DS_NS       = 20,
  parameter int T_DH_NS       = 20,
  parameter int T_RP_NS       = 20,
  parameter int T_REH_NS      = 20,
  parameter int T_RC_NS       = 40,
  parameter int T_RR_NS       = 20,
  parameter int T_CSH_WR_NS   = 10,
  parameter int T_CSH_RD_NS   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic          req_last,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          nf_cs_n,
  output logic          nf_cmd_lat,
  output logic          nf_adr_lat,
  output logic          nf_wr_n,
  output logic          nf_rd_n,
  input  logic          nf_rdy,
  output logic [DW-1:0] nf_dout,
  output logic          nf_doe,
  input  logic [DW-1:0] nf_din
);
  localparam int C_WP  = ns2cyc(T_WP_NS,  CLK_NS);
  localparam int C_LSU = ns2cyc(T_LSU_NS, CLK_NS);
  localparam int C_DS  = ns2cyc(T_DS_NS,  CLK_NS);
  localparam int P_WL  = imax(C_WP, imax(C_LSU, C_DS));
  localparam int P_LH  = ns2cyc(T_LHD_NS, CLK_NS);
  localparam int P_DH  = ns2cyc(T_DH_NS, CLK_NS);
  localparam int P_CEW = ns2cyc(T_CSH_WR_NS, CLK_NS);
  localparam int P_WHT = imax(imax(P_LH, P_DH),
                              imax(P_CEW, imax(ns2cyc(T_WH_NS, CLK_NS),
                                               ns2cyc(T_WC_NS, CLK_NS) - P_WL)));
  localparam int P_RR  = ns2cyc(T_RR_NS, CLK_NS);
  localparam int P_RL  = ns2cyc(T_RP_NS, CLK_NS);
  localparam int P_CER = ns2cyc(T_CSH_RD_NS, CLK_NS);
  localparam int P_RHT = imax(ns2cyc(T_REH_NS, CLK_NS),
                              imax(ns2cyc(T_RC_NS, CLK_NS) - P_RL, P_CER));

  logic rdy_s;
  logic cap_en;
  logic present;
  logic rd_take;

  assign rd_take = rd_valid & rd_ready;

  nfb_rdy_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (nf_rdy),
    .q     (rdy_s)
  );

  nfb_seq #(
    .DW(DW), .WL(P_WL), .LH(P_LH), .DH(P_DH), .CEW(P_CEW), .WHT(P_WHT),
    .RR(P_RR), .RL(P_RL), .CER(P_CER), .RHT(P_RHT)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_last  (req_last),
    .req_wdata (req_wdata),
    .rdy_s     (rdy_s),
    .rd_take   (rd_take),
    .req_ready (req_ready),
    .cs_n      (nf_cs_n),
    .cmd_lat   (nf_cmd_lat),
    .adr_lat   (nf_adr_lat),
    .wr_n      (nf_wr_n),
    .rd_n      (nf_rd_n),
    .doe       (nf_doe),
    .dout      (nf_dout),
    .cap_en    (cap_en),
    .present   (present),
    .done      (done)
  );

  nfb_rd_hold #(.DW(DW)) hold_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap     (cap_en),
    .din     (nf_din),
    .present (present),
    .take    (rd_take),
    .valid   (rd_valid),
    .data    (rd_data)
  );
endmodule

// File: rtl/nand_cycle_gen_chk.sv
module nand_cycle_gen_chk
  import nfb_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CLK_NS   = 4,
  parameter int T_LSU_NS = 20,
  parameter int T_LHD_NS = 40,
  parameter int T_WP_NS  = 20,
  parameter int T_DS_NS  = 20,
  parameter int T_DH_NS  = 20,
  parameter int T_RP_NS  = 20,
  parameter int T_RR_NS  = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          nf_wr_n,
  input logic          nf_rd_n,
  input logic          nf_cmd_lat,
  input logic          nf_adr_lat,
  input logic          nf_doe,
  input logic          nf_rdy,
  input logic          done,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data
);
  localparam int K_WL = imax(ns2cyc(T_WP_NS, CLK_NS),
                             imax(ns2cyc(T_LSU_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)));
  localparam int K_LH = ns2cyc(T_LHD_NS, CLK_NS);
  localparam int K_DH = ns2cyc(T_DH_NS, CLK_NS);
  localparam int K_RL = ns2cyc(T_RP_NS, CLK_NS);
  localparam int K_RR = ns2cyc(T_RR_NS, CLK_NS);

  function automatic logic [7:0] inc_sat(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

  logic [7:0] wlo, rlo, whi, rbh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wlo <= '0;
      rlo <= '0;
      whi <= '0;
      rbh <= '0;
    end else begin
      wlo <= nf_wr_n ? 8'd0 : inc_sat(wlo);
      rlo <= nf_rd_n ? 8'd0 : inc_sat(rlo);
      whi <= nf_wr_n ? inc_sat(whi) : 8'd0;
      rbh <= nf_rdy  ? inc_sat(rbh) : 8'd0;
    end
  end

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nf_wr_n && !nf_rd_n));
  assert_latch_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cmd_lat && nf_adr_lat));
  assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_wr_n) |-> (wlo == 8'(K_WL)));
  assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_cmd_lat) |-> (whi >= 8'(K_LH)));
  assert_adr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_adr_lat) |-> (whi >= 8'(K_LH)));
  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_doe) |-> (whi >= 8'(K_DH)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rdy_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_rd_n) |-> (rbh >= 8'(K_RR)));
  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_rd_n) |-> (rlo == 8'(K_RL)));
  assert_bus_turn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_doe && !nf_rd_n));
  assert_rd_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind nand_cycle_gen nand_cycle_gen_chk #(
  .DW(DW), .CLK_NS(CLK_NS), .T_LSU_NS(T_LSU_NS), .T_LHD_NS(T_LHD_NS),
  .T_WP_NS(T_WP_NS), .T_DS_NS(T_DS_NS), .T_DH_NS(T_DH_NS),
  .T_RP_NS(T_RP_NS), .T_RR_NS(T_RR_NS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .nf_wr_n    (nf_wr_n),
  .nf_rd_n    (nf_rd_n),
  .nf_cmd_lat (nf_cmd_lat),
  .nf_adr_lat (nf_adr_lat),
  .nf_doe     (nf_doe),
  .nf_rdy     (nf_rdy),
  .done       (done),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data)
);

// File: tb/nand_cycle_gen_tb_top.sv
`timescale 1ns/1ps
module nand_cycle_gen_tb_top;
  localparam int CLK_NS = 4;
  localparam int SYNC   = 2;

  function automatic int up(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    if (c < 1) c = 1;
    return c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_WL  = mx(up(20), mx(up(20), up(20)));
  localparam int E_LH  = up(40);
  localparam int E_DH  = up(20);
  localparam int E_CEW = up(10);
  localparam int E_WHT = mx(mx(E_LH, E_DH), mx(E_CEW, mx(up(20), up(40) - E_WL)));
  localparam int E_RR  = up(20);
  localparam int E_RL  = up(20);
  localparam int E_CER = up(30);
  localparam int E_RHT = mx(up(20), mx(up(40) - E_RL, E_CER));

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_last;
  logic [1:0]  req_kind;
  logic [15:0] req_wdata;
  logic        rd_valid, rd_ready;
  logic [15:0] rd_data;
  logic        done;
  logic        nf_cs_n, nf_cmd_lat, nf_adr_lat, nf_wr_n, nf_rd_n, nf_rdy, nf_doe;
  logic [15:0] nf_dout, nf_din;

  int  checks = 0;
  int  errors = 0;
  bit  prev_last = 1'b1;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  nand_cycle_gen #(.CLK_NS(CLK_NS), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_last(req_last), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .done(done),
    .nf_cs_n(nf_cs_n), .nf_cmd_lat(nf_cmd_lat), .nf_adr_lat(nf_adr_lat),
    .nf_wr_n(nf_wr_n), .nf_rd_n(nf_rd_n), .nf_rdy(nf_rdy),
    .nf_dout(nf_dout), .nf_doe(nf_doe), .nf_din(nf_din)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_write(input int kind, input logic [15:0] word, input bit last);
    int n_lo = 0, n_lat = 0, n_oe = 0, n_ce = 0, n_hold = 0, bad = 0, rdy_hi = 0, it = 0;
    @(negedge clk);
    chk(nf_cs_n == prev_last, "R10 select between cycles", nf_cs_n, prev_last);
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_kind = 2'(kind); req_wdata = word; req_last = last;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~word;
    while (!done && it < 200) begin
      if (req_ready) rdy_hi++;
      if (!nf_wr_n) begin
        n_lo++;
        if (nf_cmd_lat != (kind == 0) || nf_adr_lat != (kind == 1) ||
            !nf_doe || nf_dout != word || nf_cs_n) bad++;
      end else begin
        n_hold++;
        if (nf_cmd_lat || nf_adr_lat) n_lat++;
        if (nf_doe) begin
          n_oe++;
          if (nf_dout != word) bad++;
        end
        if (!nf_cs_n) n_ce++;
      end
      it++;
      @(negedge clk);
    end
    chk(done == 1'b1, "R6 write completes", done, 1);
    chk(n_lo == E_WL, "R3 write strobe width", n_lo, E_WL);
    chk(bad == 0, "R3 latch/bus during pulse", bad, 0);
    chk(n_lat == ((kind < 2) ? E_LH : 0), "R4 latch hold", n_lat, (kind < 2) ? E_LH : 0);
    chk(n_oe == E_DH, "R5 data hold", n_oe, E_DH);
    chk(n_hold == E_WHT, "R6 write tail", n_hold, E_WHT);
    chk(n_ce == (last ? E_CEW : E_WHT), "R10 select hold write", n_ce, last ? E_CEW : E_WHT);
    chk(rdy_hi == 0, "R2 ready low while busy", rdy_hi, 0);
    chk(nf_cs_n == last, "R10 select at done", nf_cs_n, last);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R6 done one cycle", done, 0);
    prev_last = last;
  endtask

  task automatic do_read(input logic [15:0] word, input bit last, input int dly,
                         input bit drop, input int bp);
    int gap = 0, n_lo = 0, n_hold = 0, n_ce = 0, oe_hi = 0, k = 1, it = 0;
    nf_rdy = 1'b0;
    repeat (3) @(negedge clk);
    chk(nf_cs_n == prev_last, "R10 select between cycles", nf_cs_n, prev_last);
    req_valid = 1'b1; req_kind = 2'd3; req_last = last;
    @(negedge clk);
    req_valid = 1'b0;
    while (nf_rd_n && it < 200) begin
      if (nf_doe) oe_hi++;
      if (nf_rdy) gap++; else gap = 0;
      nf_rdy = (k > dly) && !(drop && k == dly + 3);
      k++; it++;
      @(negedge clk);
    end
    chk(gap == E_RR + SYNC - 1, "R7 ready to strobe gap", gap, E_RR + SYNC - 1);
    while (!nf_rd_n && it < 200) begin
      if (nf_doe) oe_hi++;
      n_lo++;
      nf_din = (n_lo == E_RL) ? word : (word ^ 16'h5A5A);
      it++;
      @(negedge clk);
    end
    nf_din = ~word;
    chk(n_lo == E_RL, "R8 read strobe width", n_lo, E_RL);
    while (!rd_valid && it < 200) begin
      if (nf_doe) oe_hi++;
      n_hold++;
      if (!nf_cs_n) n_ce++;
      it++;
      @(negedge clk);
    end
    chk(n_hold == E_RHT, "R9 read tail", n_hold, E_RHT);
    chk(n_ce == (last ? E_CER : E_RHT), "R10 select hold read", n_ce, last ? E_CER : E_RHT);
    chk(oe_hi == 0, "R8 bus released on read", oe_hi, 0);
    for (int j = 0; j <= bp; j++) begin
      chk(rd_valid && rd_data == word && !done, "R9 held read word", rd_data, word);
      if (j == bp) rd_ready = 1'b1;
      @(negedge clk);
    end
    rd_ready = 1'b0;
    chk(done == 1'b1 && rd_valid == 1'b0, "R9 done after handshake", done, 1);
    chk(nf_cs_n == last, "R10 select at read done", nf_cs_n, last);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    prev_last = last;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3; pats[3] = 16'h1234;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_last = 1'b0;
    req_wdata = '0; rd_ready = 1'b0; nf_rdy = 1'b0; nf_din = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(nf_cs_n && nf_wr_n && nf_rd_n, "R1 strobes idle high", {nf_cs_n, nf_wr_n, nf_rd_n}, 7);
    chk(!nf_cmd_lat && !nf_adr_lat && !nf_doe, "R1 latches and bus off",
        {nf_cmd_lat, nf_adr_lat, nf_doe}, 0);
    chk(req_ready && !done && !rd_valid, "R1 handshake idle", {req_ready, done, rd_valid}, 4);

    for (int kind = 0; kind < 3; kind++)
      for (int l = 0; l < 2; l++)
        for (int p = 0; p < 4; p++)
          do_write(kind, pats[p] ^ 16'(kind * 257), l[0]);

    for (int d = 0; d < 4; d++)
      for (int dr = 0; dr < 2; dr++)
        for (int bp = 0; bp < 3; bp++)
          do_read(16'h3C00 ^ 16'(d * 37 + dr * 5 + bp * 1001), (bp != 1), d, dr[0], bp);

    do_write(0, 16'h0070, 1'b0);
    do_write(1, 16'h0012, 1'b0);
    do_read(16'hBEEF, 1'b0, 1, 1'b0, 0);
    do_read(16'h8001, 1'b1, 2, 1'b1, 2);
    do_write(2, 16'h55AA, 1'b1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule